// File: doc/BRIEF.md
# VBI Line Blanking Controller

This block decides, one video line at a time, whether the content of a vertical-blanking line may reach the output or must be blanked. It also produces a corrected vertical-blanking flag for the embedded timing reference codes. Its inputs are the current line number, the selected video standard, two enable bits, a flag for the first slave timing mode, and the blanking bit taken from the incoming timing code. The line number counts within a field for the interlaced standard-definition formats and within a frame for the progressive formats.

Each standard allows data through only on its own range of lines. On standard-definition interlaced NTSC, lines 10 through 20 may carry data. On PAL the range is 7 through 22. On progressive 525-line video it is 13 through 42, and on progressive 625-line video it is 6 through 43. A blanking line outside its range is always blanked. When the enable bit for the active family is low, every blanking line is blanked in every timing mode. In the first slave timing mode with the enable set, the block clears the outgoing blanking flag on lines that pass. Downstream logic then treats those lines as carrying data. In all other cases the flag is copied from the input.

The decision is held in a three-state line classifier: ST_VBI_BLANK, ST_VBI_PASS and ST_ACTIVE. Every clock edge moves it to the state that fits the inputs sampled at that edge. Any state can move to any other. A cleared incoming blanking bit leads to ST_ACTIVE. A set bit with the enable on and the line inside the range leads to ST_VBI_PASS. Any other set bit leads to ST_VBI_BLANK, which is also the reset state. Both outputs come from the registered state, so each one lags its inputs by one clock.

Top module: `vbi_line_gate`

## Requirements
- R1: With vid_std = 0 (NTSC), sd_vbi_en = 1 and blank_in = 1, line_pass is 1 for lines 10 to 20 inclusive and 0 for lines 9 and 21.
- R2: With vid_std = 1 (PAL), sd_vbi_en = 1 and blank_in = 1, line_pass is 1 for lines 7 to 22 inclusive and 0 for lines 6 and 23.
- R3: With vid_std = 2 (525p), hd_vbi_en = 1 and blank_in = 1, line_pass is 1 for lines 13 to 42 inclusive and 0 for lines 12 and 43.
- R4: With vid_std = 3 (625p), hd_vbi_en = 1 and blank_in = 1, line_pass is 1 for lines 6 to 43 inclusive and 0 for lines 5 and 44.
- R5: A line with blank_in = 1 that lies outside the range for its standard gives line_pass = 0 and blank_out = 1, whatever the enables and timing mode.
- R6: When the enable for the selected family is 0, every line with blank_in = 1 gives line_pass = 0 and blank_out = 1, with slave_mode0 either 0 or 1.
- R7: Standards 0 and 1 use only sd_vbi_en, and standards 2 and 3 use only hd_vbi_en. The enable of the other family has no effect on line_pass.
- R8: A line with blank_in = 0 (active video) gives line_pass = 1 and blank_out = 0, whatever the enables.
- R9: With slave_mode0 = 1 and the family enable set, a passing blanking line gives blank_out = 0. With slave_mode0 = 0, blank_out equals blank_in of the previous clock.
- R10: Both outputs change on the first rising clock edge after the inputs change, and not before.
- R11: While rst_n is low, line_pass = 0 and blank_out = 1. Reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | LINE_W (11) | Current line number (per field for SD, per frame for progressive) |
| vid_std | input | 2 | Standard: 0 NTSC, 1 PAL, 2 525p, 3 625p |
| sd_vbi_en | input | 1 | VBI pass enable for standards 0 and 1 |
| hd_vbi_en | input | 1 | VBI pass enable for standards 2 and 3 |
| slave_mode0 | input | 1 | High when the first slave timing mode is selected |
| blank_in | input | 1 | Vertical blanking bit from the incoming timing code |
| line_pass | output | 1 | 1 = pass line data, 0 = blank the line |
| blank_out | output | 1 | Corrected vertical blanking bit for the outgoing timing code |

## Verification
On every clock the assertions check four rules: active lines always pass, a disabled family blanks its whole interval, out-of-range blanking lines are blanked, and the outgoing flag follows the incoming one outside the first slave mode. They also check that a passing line in that mode has its flag cleared. The exact edges of each standard's range, the fact that only the matching family's enable is used, and the one-clock lag can only be shown by the bench's vectors. The bench steps across each boundary line and samples the outputs just before and just after the capturing edge.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

    typedef enum logic [1:0] {
        STD_NTSC = 2'd0,
        STD_PAL  = 2'd1,
        STD_P525 = 2'd2,
        STD_P625 = 2'd3
    } vid_std_e;

    typedef enum logic [1:0] {
        ST_VBI_BLANK = 2'd0,
        ST_VBI_PASS  = 2'd1,
        ST_ACTIVE    = 2'd2
    } line_st_e;

    localparam int NUM_STD = 4;

endpackage

// File: rtl/vbi_window_match.sv
module vbi_window_match
    import vbi_gate_pkg::*;
#(
    parameter int LINE_W  = 11,
    parameter int NTSC_LO = 10,
    parameter int NTSC_HI = 20,
    parameter int PAL_LO  = 7,
    parameter int PAL_HI  = 22,
    parameter int P525_LO = 13,
    parameter int P525_HI = 42,
    parameter int P625_LO = 6,
    parameter int P625_HI = 43
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic [1:0]        vid_std,
    output logic              in_window
);

    localparam int LO_TAB [NUM_STD] = '{NTSC_LO, PAL_LO, P525_LO, P625_LO};
    localparam int HI_TAB [NUM_STD] = '{NTSC_HI, PAL_HI, P525_HI, P625_HI};

    logic [NUM_STD-1:0] hit;

    for (genvar g = 0; g < NUM_STD; g++) begin : g_std
        localparam logic [LINE_W-1:0] LO_V = LINE_W'(LO_TAB[g]);
        localparam logic [LINE_W-1:0] HI_V = LINE_W'(HI_TAB[g]);
        assign hit[g] = (line_num >= LO_V) && (line_num <= HI_V);
    end

    assign in_window = hit[vid_std];

endmodule

// File: rtl/vbi_enable_select.sv
module vbi_enable_select
    import vbi_gate_pkg::*;
(
    input  logic [1:0] vid_std,
    input  logic       sd_vbi_en,
    input  logic       hd_vbi_en,
    output logic       vbi_en
);

    always_comb begin
        unique case (vid_std_e'(vid_std))
            STD_NTSC, STD_PAL:  vbi_en = sd_vbi_en;
            STD_P525, STD_P625: vbi_en = hd_vbi_en;
        endcase
    end

endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate
    import vbi_gate_pkg::*;
#(
    parameter int LINE_W  = 11,
    parameter int NTSC_LO = 10,
    parameter int NTSC_HI = 20,
    parameter int PAL_LO  = 7,
    parameter int PAL_HI  = 22,
    parameter int P525_LO = 13,
    parameter int P525_HI = 42,
    parameter int P625_LO = 6,
    parameter int P625_HI = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic [1:0]        vid_std,
    input  logic              sd_vbi_en,
    input  logic              hd_vbi_en,
    input  logic              slave_mode0,
    input  logic              blank_in,
    output logic              line_pass,
    output logic              blank_out
);

    logic      in_window;
    logic      vbi_en;
    line_st_e  state_q, state_d;
    logic      ovr_q;

    vbi_window_match #(
        .LINE_W (LINE_W),
        .NTSC_LO(NTSC_LO), .NTSC_HI(NTSC_HI),
        .PAL_LO (PAL_LO),  .PAL_HI (PAL_HI),
        .P525_LO(P525_LO), .P525_HI(P525_HI),
        .P625_LO(P625_LO), .P625_HI(P625_HI)
    ) u_win (
        .line_num (line_num),
        .vid_std  (vid_std),
        .in_window(in_window)
    );

    vbi_enable_select u_en (
        .vid_std  (vid_std),
        .sd_vbi_en(sd_vbi_en),
        .hd_vbi_en(hd_vbi_en),
        .vbi_en   (vbi_en)
    );

    // Next-state choice: every state may reach every other in one step.
    always_comb begin
        if (!blank_in) begin
            state_d = ST_ACTIVE;
        end else if (vbi_en && in_window) begin
            state_d = ST_VBI_PASS;
        end else begin
            state_d = ST_VBI_BLANK;
        end
    end

    // State register; reset lands in the safe, fully blanked state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_VBI_BLANK;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovr_q   <= slave_mode0 && vbi_en;
        end
    end

    // Outputs decoded from the registered classification.
    always_comb begin
        unique case (state_q)
            ST_ACTIVE: begin
                line_pass = 1'b1;
                blank_out = 1'b0;
            end
            ST_VBI_PASS: begin
                line_pass = 1'b1;
                blank_out = !ovr_q;
            end
            ST_VBI_BLANK: begin
                line_pass = 1'b0;
                blank_out = 1'b1;
            end
            default: begin
                line_pass = 1'b0;
                blank_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/vbi_line_gate_chk.sv
module vbi_line_gate_chk #(
    parameter int LINE_W  = 11,
    parameter int NTSC_LO = 10,
    parameter int NTSC_HI = 20,
    parameter int PAL_LO  = 7,
    parameter int PAL_HI  = 22,
    parameter int P525_LO = 13,
    parameter int P525_HI = 42,
    parameter int P625_LO = 6,
    parameter int P625_HI = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] line_num,
    input logic [1:0]        vid_std,
    input logic              sd_vbi_en,
    input logic              hd_vbi_en,
    input logic              slave_mode0,
    input logic              blank_in,
    input logic              line_pass,
    input logic              blank_out
);

    logic en_ref;
    logic win_ref;
    int   lo_ref, hi_ref;

    always_comb begin
        case (vid_std)
            2'd0:    begin lo_ref = NTSC_LO; hi_ref = NTSC_HI; end
            2'd1:    begin lo_ref = PAL_LO;  hi_ref = PAL_HI;  end
            2'd2:    begin lo_ref = P525_LO; hi_ref = P525_HI; end
            default: begin lo_ref = P625_LO; hi_ref = P625_HI; end
        endcase
        en_ref  = vid_std[1] ? hd_vbi_en : sd_vbi_en;
        win_ref = (int'(line_num) >= lo_ref) && (int'(line_num) <= hi_ref);
    end

    // R8
    active_line_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_in |=> (line_pass && !blank_out));

    // R6
    vbi_off_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_in && !en_ref) |=> (!line_pass && blank_out));

    // R5
    outside_window_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_in && !win_ref) |=> (!line_pass && blank_out));

    // R9
    flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode0 |=> (blank_out == $past(blank_in)));

    // R9
    slave0_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode0 && blank_in && en_ref && win_ref) |=> (line_pass && !blank_out));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_pass && blank_out));

endmodule

bind vbi_line_gate vbi_line_gate_chk #(
    .LINE_W (LINE_W),
    .NTSC_LO(NTSC_LO), .NTSC_HI(NTSC_HI),
    .PAL_LO (PAL_LO),  .PAL_HI (PAL_HI),
    .P525_LO(P525_LO), .P525_HI(P525_HI),
    .P625_LO(P625_LO), .P625_HI(P625_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_num   (line_num),
    .vid_std    (vid_std),
    .sd_vbi_en  (sd_vbi_en),
    .hd_vbi_en  (hd_vbi_en),
    .slave_mode0(slave_mode0),
    .blank_in   (blank_in),
    .line_pass  (line_pass),
    .blank_out  (blank_out)
);

// File: tb/vbi_line_gate_tb.sv
`timescale 1ns/1ps
module vbi_line_gate_tb;

    localparam int LINE_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic [1:0]        vid_std = 2'd0;
    logic              sd_vbi_en = 1'b0;
    logic              hd_vbi_en = 1'b0;
    logic              slave_mode0 = 1'b0;
    logic              blank_in = 1'b0;
    logic              line_pass;
    logic              blank_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    vbi_line_gate #(.LINE_W(LINE_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_num   (line_num),
        .vid_std    (vid_std),
        .sd_vbi_en  (sd_vbi_en),
        .hd_vbi_en  (hd_vbi_en),
        .slave_mode0(slave_mode0),
        .blank_in   (blank_in),
        .line_pass  (line_pass),
        .blank_out  (blank_out)
    );

    // Vector: {req[4], std[2], line[11], blank_in, sd_en, hd_en, slave0, exp_pass, exp_blank}
    localparam int VW = 23;
    localparam int NV = 32;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd1,  2'd0, 11'd9,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 below
        {4'd1,  2'd0, 11'd10,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 first
        {4'd1,  2'd0, 11'd20,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 last
        {4'd1,  2'd0, 11'd21,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 above
        {4'd2,  2'd1, 11'd6,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
        {4'd2,  2'd1, 11'd7,   1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
        {4'd2,  2'd1, 11'd22,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
        {4'd2,  2'd1, 11'd23,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
        {4'd3,  2'd2, 11'd12,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
        {4'd3,  2'd2, 11'd13,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3
        {4'd3,  2'd2, 11'd42,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3
        {4'd3,  2'd2, 11'd43,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
        {4'd4,  2'd3, 11'd5,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
        {4'd4,  2'd3, 11'd6,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
        {4'd4,  2'd3, 11'd43,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
        {4'd4,  2'd3, 11'd44,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
        {4'd5,  2'd1, 11'd30,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 slave0 out of range
        {4'd5,  2'd3, 11'd2,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
        {4'd6,  2'd0, 11'd15,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 sd off
        {4'd6,  2'd0, 11'd15,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 sd off, slave0
        {4'd6,  2'd3, 11'd20,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 hd off, slave0
        {4'd7,  2'd2, 11'd20,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 sd on ignored for 525p
        {4'd7,  2'd1, 11'd15,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 hd off ignored for PAL
        {4'd7,  2'd1, 11'd15,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 hd on ignored for PAL
        {4'd8,  2'd0, 11'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8
        {4'd8,  2'd3, 11'd300, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8
        {4'd8,  2'd0, 11'd15,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 in range but active
        {4'd9,  2'd0, 11'd15,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 override
        {4'd9,  2'd2, 11'd20,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 override
        {4'd9,  2'd3, 11'd43,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 override at edge
        {4'd9,  2'd3, 11'd43,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R9 no override
        {4'd9,  2'd1, 11'd22,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}  // R9 no override
    };

    task automatic check(input int req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d: {line_pass,blank_out} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] v);
        vid_std     = v[18:17];
        line_num    = v[16:6];
        blank_in    = v[5];
        sd_vbi_en   = v[4];
        hd_vbi_en   = v[3];
        slave_mode0 = v[2];
    endtask

    initial begin
        // R11: reset state with inputs that would otherwise pass
        drive({4'd0, 2'd0, 11'd50, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00});
        repeat (3) @(negedge clk);
        check(11, {line_pass, blank_out}, 2'b01); // R11
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(int'(VEC[i][22:19]), {line_pass, blank_out}, VEC[i][1:0]);
        end

        // R10: no change before the capturing edge, change right after it
        drive({4'd0, 2'd0, 11'd9, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00});
        @(negedge clk);
        check(10, {line_pass, blank_out}, 2'b01); // R10 settle blanked
        drive({4'd0, 2'd0, 11'd200, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00});
        #1;
        check(10, {line_pass, blank_out}, 2'b01); // R10 before edge
        @(posedge clk);
        #0.5;
        check(10, {line_pass, blank_out}, 2'b10); // R10 after edge

        // R11: asynchronous reset mid-run
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #0.5;
        check(11, {line_pass, blank_out}, 2'b01); // R11 async
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(8, {line_pass, blank_out}, 2'b10); // R8 after reset release

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule